// File: doc/BRIEF.md
# Auxiliary Keyboard Merge and Hot-Plug Manager

This block looks after a second, downstream keyboard-compatible device that hangs off a keyboard controller. It works out whether such a device is attached. Whenever one appears, at power-up or at any later time, it runs a reset and initialization exchange with the device. It then forwards host commands and LED settings to the device. The serial line protocol on both sides sits outside this block. Every byte exchange is a simple valid/ready or valid-pulse handshake. The only raw line the block sees is the downstream clock line, which it samples to catch device activity.

Bytes coming from the attached device share one FIFO toward the host with key codes produced by the local key matrix, so the host sees a single stream. When both sources offer a byte in the same cycle, the local byte goes in first. When the FIFO runs out of space, bytes are dropped and a sticky overflow flag is raised. Presence is judged by replies: a device that does not answer the reset command, or a periodic echo probe, within a timeout is marked absent. While a device is present, the block holds off the controller's sleep mode.

Top module: `aux_kbd_merge`

## Requirements
- R1: After reset the device-present flag, sleep inhibit, overflow flag and host-side valid are all 0. The reset command byte 0xFF is offered to the device at once.
- R2: A 0xFA reply received within TIMEOUT cycles after the reset byte is accepted sets the device-present flag. If no 0xFA arrives, the block marks the device absent and offers no byte to the device.
- R3: While the device is absent, any level change on the downstream clock line starts a new exchange that begins with the reset byte 0xFF.
- R4: Sleep inhibit is high exactly while the device-present flag is high.
- R5: After each successful reset reply, the block sends 0xED, waits for a reply, and then sends the LED byte {5'b0, led[2:0]}. Here led is the last LED setting received, including one received while no device was present; it is 0 after reset.
- R6: An LED setting received while a device is present and idle is sent as 0xED followed by the LED byte {5'b0, led[2:0]}.
- R7: A host command is sent to the device only after the host acknowledge pulse for it has been seen. Commands received while no device is present are discarded. The device's reply to any byte the block sent is consumed and not queued toward the host.
- R8: After PROBE_PERIOD cycles idle with a device present, the block sends the echo probe 0xEE. If no reply arrives within TIMEOUT cycles, the device is marked absent.
- R9: Device bytes are queued only while a device is present and no reply is awaited. Bytes arriving while the device is absent are ignored.
- R10: When the local and device bytes arrive in the same cycle, the local byte is queued first.
- R11: The FIFO delivers bytes to the host in the order they were queued, one byte per cycle in which host ready is high and host valid is high.
- R12: With DEPTH entries held, further bytes are dropped. With one free entry and two offered bytes, the local byte is kept. Any drop sets the overflow flag, which then stays set until reset.
- R13: A byte offered to the device stays valid and unchanged until the device side accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_clk_line | input | 1 | Downstream device clock line (idle high) |
| dev_rx_valid | input | 1 | Byte received from the device (one-cycle pulse) |
| dev_rx_data | input | 8 | Received device byte |
| dev_tx_valid | output | 1 | Byte offered to the device |
| dev_tx_data | output | 8 | Byte for the device |
| dev_tx_ready | input | 1 | Device side accepts the offered byte |
| loc_valid | input | 1 | Local matrix byte available (one-cycle pulse) |
| loc_data | input | 8 | Local matrix byte |
| host_cmd_valid | input | 1 | Host command byte received |
| host_cmd_data | input | 8 | Host command byte |
| host_ack | input | 1 | Acknowledge for the held command has gone to the host |
| led_valid | input | 1 | New LED setting from the host |
| led_data | input | 3 | LED setting bits |
| hq_valid | output | 1 | Host-side FIFO has a byte |
| hq_data | output | 8 | Head byte of the FIFO |
| hq_ready | input | 1 | Host side takes the head byte |
| dev_present | output | 1 | Downstream device is present |
| sleep_inhibit | output | 1 | Sleep must not be entered |
| fifo_ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
The presence logic is driven through four cases. A silent device after power-up separates a reply-based judgment from one that assumes presence. A clock-line toggle while absent shows that attach detection starts the reset exchange. A correct 0xFA reply followed by the LED replay shows that stored LED state survives an absence. An unanswered echo probe shows that a detach is found without help from the host. The merge path is tried with a simultaneous local and device byte, which fixes the arbitration order. It is also tried with a near-full FIFO receiving two bytes, which separates keeping the local byte from keeping the device byte and proves the flag is sticky. Device bytes sent while absent or as command replies are checked to stay out of the host stream. A host command held without an acknowledge is checked to stay off the device side.

// File: rtl/akm_pkg.sv
package akm_pkg;

  typedef enum logic [1:0] {
    ST_ABSENT,
    ST_SEND,
    ST_WAIT,
    ST_IDLE
  } link_st_t;

  typedef enum logic [2:0] {
    K_RESET,
    K_LEDCMD,
    K_LEDVAL,
    K_HOSTCMD,
    K_PROBE
  } out_kind_t;

  localparam logic [7:0] BYTE_RESET = 8'hFF;
  localparam logic [7:0] BYTE_ACK   = 8'hFA;
  localparam logic [7:0] BYTE_LED   = 8'hED;
  localparam logic [7:0] BYTE_PROBE = 8'hEE;

  // number of write slots granted when 'asked' bytes arrive at a queue holding 'used'
  function automatic int unsigned slots_granted(int unsigned used, int unsigned depth,
                                                int unsigned asked);
    int unsigned free_slots;
    free_slots = depth - used;
    return (asked < free_slots) ? asked : free_slots;
  endfunction

  // LED setting widened into the byte sent to the device
  function automatic logic [7:0] led_byte(logic [2:0] led);
    return {5'b00000, led};
  endfunction

endpackage

// File: rtl/akm_edge_sync.sv
module akm_edge_sync #(
  parameter int STAGES     = 2,
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic act_evt
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){IDLE_LEVEL}};
    else        chain <= {chain[STAGES-1:0], line_in};
  end

  // any transition after synchronization is one activity event
  assign act_evt = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/akm_merge_fifo.sv
module akm_merge_fifo
  import akm_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_a,
  input  logic [W-1:0] data_a,
  input  logic         push_b,
  input  logic [W-1:0] data_b,
  input  logic         pop_req,
  output logic         not_empty,
  output logic [W-1:0] head,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          take_a, take_b, do_pop, drop_evt;
  int unsigned   grant;
  logic [CW-1:0] n_in;

  always_comb begin
    grant    = slots_granted(32'(cnt), DEPTH, 32'(push_a) + 32'(push_b));
    take_a   = push_a && (grant >= 1);
    take_b   = push_b && (grant >= (push_a ? 32'd2 : 32'd1));
    drop_evt = (push_a && !take_a) || (push_b && !take_b);
    do_pop   = pop_req && (cnt != '0);
    n_in     = CW'(take_a) + CW'(take_b);
  end

  always_ff @(posedge clk) begin
    if (take_a) mem[wptr] <= data_a;
    if (take_b) mem[take_a ? AW'(wptr + 1'b1) : wptr] <= data_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      wptr <= wptr + AW'(n_in);
      if (do_pop) rptr <= rptr + 1'b1;
      cnt <= cnt + n_in - CW'(do_pop);
      if (drop_evt) ovf <= 1'b1;
    end
  end

  assign not_empty = (cnt != '0);
  assign head      = mem[rptr];

  // R12
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R11
  pop_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && not_empty && !push_a && !push_b) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/akm_link_seq.sv
module akm_link_seq
  import akm_pkg::*;
#(
  parameter int TIMEOUT      = 64,
  parameter int PROBE_PERIOD = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_evt,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_ready,
  input  logic       host_cmd_valid,
  input  logic [7:0] host_cmd_data,
  input  logic       host_ack,
  input  logic       led_valid,
  input  logic [2:0] led_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       present,
  output logic       rx_forward
);
  localparam int TMAX = (PROBE_PERIOD > TIMEOUT) ? PROBE_PERIOD : TIMEOUT;
  localparam int TW   = $clog2(TMAX + 1);

  link_st_t  state;
  out_kind_t kind;
  logic [7:0]    out_byte;
  logic [TW-1:0] tmr;
  logic [2:0]    led_reg;
  logic          led_pend;
  logic [7:0]    cmd_byte;
  logic          cmd_have, cmd_go;

  // named internal events
  logic wait_ok, wait_tmo, probe_due;

  always_comb begin
    wait_ok   = (state == ST_WAIT) && rx_valid &&
                ((kind != K_RESET) || (rx_data == BYTE_ACK));
    wait_tmo  = (state == ST_WAIT) && !wait_ok && (tmr == TW'(TIMEOUT - 1));
    probe_due = (state == ST_IDLE) && (tmr == TW'(PROBE_PERIOD - 1));
  end

  assign tx_valid   = (state == ST_SEND);
  assign tx_data    = out_byte;
  assign rx_forward = rx_valid && present && (state != ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SEND;
      kind     <= K_RESET;
      out_byte <= BYTE_RESET;
      tmr      <= '0;
      present  <= 1'b0;
      led_reg  <= '0;
      led_pend <= 1'b0;
      cmd_byte <= '0;
      cmd_have <= 1'b0;
      cmd_go   <= 1'b0;
    end else begin
      case (state)
        ST_ABSENT: begin
          if (act_evt) begin
            state    <= ST_SEND;
            kind     <= K_RESET;
            out_byte <= BYTE_RESET;
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            state <= ST_WAIT;
            tmr   <= '0;
          end
        end
        ST_WAIT: begin
          tmr <= tmr + 1'b1;
          if (wait_ok) begin
            tmr <= '0;
            case (kind)
              K_RESET: begin
                present  <= 1'b1;
                led_pend <= 1'b1;
                state    <= ST_IDLE;
              end
              K_LEDCMD: begin
                state    <= ST_SEND;
                kind     <= K_LEDVAL;
                out_byte <= led_byte(led_reg);
              end
              default: state <= ST_IDLE;
            endcase
          end else if (wait_tmo) begin
            present  <= 1'b0;
            cmd_have <= 1'b0;
            cmd_go   <= 1'b0;
            state    <= ST_ABSENT;
          end
        end
        default: begin
          tmr <= tmr + 1'b1;
          if (led_pend) begin
            led_pend <= 1'b0;
            state    <= ST_SEND;
            kind     <= K_LEDCMD;
            out_byte <= BYTE_LED;
          end else if (cmd_go) begin
            cmd_have <= 1'b0;
            cmd_go   <= 1'b0;
            state    <= ST_SEND;
            kind     <= K_HOSTCMD;
            out_byte <= cmd_byte;
          end else if (probe_due) begin
            state    <= ST_SEND;
            kind     <= K_PROBE;
            out_byte <= BYTE_PROBE;
          end
        end
      endcase

      if (led_valid) begin
        led_reg  <= led_data;
        led_pend <= 1'b1;
      end
      if (host_ack && cmd_have && !cmd_go && (state != ST_ABSENT)) cmd_go <= 1'b1;
      if (host_cmd_valid && present) begin
        cmd_byte <= host_cmd_data;
        cmd_have <= 1'b1;
        cmd_go   <= 1'b0;
      end
    end
  end

  // R2
  present_from_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present) |-> $past(rx_valid && (rx_data == BYTE_ACK)));

  // R3
  attach_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ABSENT) && act_evt) |=> (tx_valid && (tx_data == BYTE_RESET)));

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  no_fwd_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !rx_forward);
endmodule

// File: rtl/aux_kbd_merge.sv
module aux_kbd_merge #(
  parameter int DEPTH        = 8,
  parameter int TIMEOUT      = 64,
  parameter int PROBE_PERIOD = 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_clk_line,
  input  logic       dev_rx_valid,
  input  logic [7:0] dev_rx_data,
  output logic       dev_tx_valid,
  output logic [7:0] dev_tx_data,
  input  logic       dev_tx_ready,
  input  logic       loc_valid,
  input  logic [7:0] loc_data,
  input  logic       host_cmd_valid,
  input  logic [7:0] host_cmd_data,
  input  logic       host_ack,
  input  logic       led_valid,
  input  logic [2:0] led_data,
  output logic       hq_valid,
  output logic [7:0] hq_data,
  input  logic       hq_ready,
  output logic       dev_present,
  output logic       sleep_inhibit,
  output logic       fifo_ovf
);
  logic act_evt;
  logic rx_forward;
  logic present;

  akm_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(aux_clk_line), .act_evt(act_evt)
  );

  akm_link_seq #(.TIMEOUT(TIMEOUT), .PROBE_PERIOD(PROBE_PERIOD)) u_seq (
    .clk(clk), .rst_n(rst_n), .act_evt(act_evt),
    .rx_valid(dev_rx_valid), .rx_data(dev_rx_data), .tx_ready(dev_tx_ready),
    .host_cmd_valid(host_cmd_valid), .host_cmd_data(host_cmd_data), .host_ack(host_ack),
    .led_valid(led_valid), .led_data(led_data),
    .tx_valid(dev_tx_valid), .tx_data(dev_tx_data),
    .present(present), .rx_forward(rx_forward)
  );

  // local matrix on the priority port
  akm_merge_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_a(loc_valid), .data_a(loc_data),
    .push_b(rx_forward), .data_b(dev_rx_data),
    .pop_req(hq_ready), .not_empty(hq_valid), .head(hq_data), .ovf(fifo_ovf)
  );

  assign dev_present   = present;
  assign sleep_inhibit = present;

  // R4
  sleep_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_present) |-> !sleep_inhibit);
endmodule

// File: tb/aux_kbd_merge_test.sv
`timescale 1ns/1ps
module aux_kbd_merge_test;
  localparam int DEPTH = 8;
  localparam int TMO   = 100;
  localparam int PRB   = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aux_clk_line = 1'b1;
  logic dev_rx_valid = 1'b0;
  logic [7:0] dev_rx_data = '0;
  logic dev_tx_valid;
  logic [7:0] dev_tx_data;
  logic dev_tx_ready = 1'b0;
  logic loc_valid = 1'b0;
  logic [7:0] loc_data = '0;
  logic host_cmd_valid = 1'b0;
  logic [7:0] host_cmd_data = '0;
  logic host_ack = 1'b0;
  logic led_valid = 1'b0;
  logic [2:0] led_data = '0;
  logic hq_valid;
  logic [7:0] hq_data;
  logic hq_ready = 1'b0;
  logic dev_present, sleep_inhibit, fifo_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aux_kbd_merge #(.DEPTH(DEPTH), .TIMEOUT(TMO), .PROBE_PERIOD(PRB)) uut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // wait for a byte to the device, check it, accept it
  task automatic take_tx(logic [7:0] exp, string tag, int limit);
    int k = 0;
    while (!dev_tx_valid && k < limit) begin
      @(negedge clk);
      k++;
    end
    check({tag, " tx valid"}, 8'(dev_tx_valid), 8'd1);
    check({tag, " tx byte"}, dev_tx_data, exp);
    dev_tx_ready = 1'b1;
    @(negedge clk);
    dev_tx_ready = 1'b0;
  endtask

  task automatic give_rx(logic [7:0] b);
    dev_rx_valid = 1'b1;
    dev_rx_data  = b;
    @(negedge clk);
    dev_rx_valid = 1'b0;
  endtask

  task automatic pop_hq(logic [7:0] exp, string tag);
    check({tag, " hq valid"}, 8'(hq_valid), 8'd1);
    check({tag, " hq byte"}, hq_data, exp);
    hq_ready = 1'b1;
    @(negedge clk);
    hq_ready = 1'b0;
  endtask

  task automatic toggle_line();
    aux_clk_line = ~aux_clk_line;
    cyc(5);
  endtask

  task automatic t_reset();
    cyc(1);
    check("R1 present", 8'(dev_present), 8'd0);
    check("R1 sleep", 8'(sleep_inhibit), 8'd0);
    check("R1 ovf", 8'(fifo_ovf), 8'd0);
    check("R1 hq valid", 8'(hq_valid), 8'd0);
    check("R1 tx valid", 8'(dev_tx_valid), 8'd1);
    check("R1 tx byte", dev_tx_data, 8'hFF);
    cyc(4);
    check("R13 held valid", 8'(dev_tx_valid), 8'd1);
    check("R13 held byte", dev_tx_data, 8'hFF);
  endtask

  task automatic t_no_device();
    take_tx(8'hFF, "R2 powerup", 5);
    cyc(TMO + 5);
    check("R2 absent", 8'(dev_present), 8'd0);
    check("R2 quiet", 8'(dev_tx_valid), 8'd0);
    // LED setting while absent is stored for later replay
    led_data = 3'b101; led_valid = 1'b1; cyc(1); led_valid = 1'b0;
    cyc(3);
    check("R5 no send while absent", 8'(dev_tx_valid), 8'd0);
  endtask

  task automatic t_attach();
    toggle_line();
    take_tx(8'hFF, "R3 attach", 10);
    give_rx(8'hFA);
    cyc(1);
    check("R2 present", 8'(dev_present), 8'd1);
    check("R4 sleep high", 8'(sleep_inhibit), 8'd1);
    take_tx(8'hED, "R5 replay cmd", 10);
    give_rx(8'hFA);
    take_tx(8'h05, "R5 replay led", 10);
    give_rx(8'hFA);
    cyc(3);
    check("R7 replies not queued", 8'(hq_valid), 8'd0);
  endtask

  task automatic t_host_cmd();
    host_cmd_data = 8'hF4; host_cmd_valid = 1'b1; cyc(1); host_cmd_valid = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (dev_tx_valid) seen++;
        cyc(1);
      end
      check("R7 held before ack", 8'(seen), 8'd0);
    end
    host_ack = 1'b1; cyc(1); host_ack = 1'b0;
    take_tx(8'hF4, "R7 forwarded", 10);
    give_rx(8'hFA);
    cyc(3);
    check("R7 reply consumed", 8'(hq_valid), 8'd0);
  endtask

  task automatic t_led_update();
    led_data = 3'b010; led_valid = 1'b1; cyc(1); led_valid = 1'b0;
    take_tx(8'hED, "R6 led cmd", 10);
    give_rx(8'hFA);
    take_tx(8'h02, "R6 led byte", 10);
    give_rx(8'hFA);
    cyc(2);
  endtask

  task automatic t_merge();
    loc_valid = 1'b1; loc_data = 8'h31;
    dev_rx_valid = 1'b1; dev_rx_data = 8'h42;
    cyc(1);
    loc_valid = 1'b0;
    dev_rx_data = 8'h43;
    cyc(1);
    dev_rx_valid = 1'b0;
    cyc(1);
    pop_hq(8'h31, "R10 local first");
    pop_hq(8'h42, "R10 device second");
    pop_hq(8'h43, "R11 order");
    check("R11 empty", 8'(hq_valid), 8'd0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH - 1; i++) begin
      loc_valid = 1'b1; loc_data = 8'(8'h60 + i);
      cyc(1);
    end
    loc_valid = 1'b0;
    check("R12 no ovf yet", 8'(fifo_ovf), 8'd0);
    loc_valid = 1'b1; loc_data = 8'h77;
    dev_rx_valid = 1'b1; dev_rx_data = 8'h88;
    cyc(1);
    loc_valid = 1'b0; dev_rx_valid = 1'b0;
    cyc(1);
    check("R12 ovf set", 8'(fifo_ovf), 8'd1);
    for (int i = 0; i < DEPTH - 1; i++) pop_hq(8'(8'h60 + i), "R12 drain");
    pop_hq(8'h77, "R12 local kept");
    check("R12 device dropped", 8'(hq_valid), 8'd0);
    check("R12 ovf sticky", 8'(fifo_ovf), 8'd1);
  endtask

  task automatic t_probe();
    take_tx(8'hEE, "R8 probe", PRB + 50);
    cyc(TMO + 5);
    check("R8 absent", 8'(dev_present), 8'd0);
    check("R4 sleep low", 8'(sleep_inhibit), 8'd0);
    give_rx(8'h55);
    cyc(3);
    check("R9 absent rx ignored", 8'(hq_valid), 8'd0);
    host_cmd_data = 8'hF5; host_cmd_valid = 1'b1; cyc(1); host_cmd_valid = 1'b0;
    host_ack = 1'b1; cyc(1); host_ack = 1'b0;
    led_data = 3'b110; led_valid = 1'b1; cyc(1); led_valid = 1'b0;
  endtask

  task automatic t_reattach();
    toggle_line();
    take_tx(8'hFF, "R3 reattach", 10);
    give_rx(8'hFA);
    take_tx(8'hED, "R5 second replay", 10);
    give_rx(8'hFA);
    take_tx(8'h06, "R5 last led", 10);
    give_rx(8'hFA);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (dev_tx_valid) seen++;
        cyc(1);
      end
      check("R7 absent cmd dropped", 8'(seen), 8'd0);
    end
    check("R2 present again", 8'(dev_present), 8'd1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_no_device();
    t_attach();
    t_host_cmd();
    t_led_update();
    t_merge();
    t_overflow();
    t_probe();
    t_reattach();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule